// File: doc/BRIEF.md
# PCM highway time-slot transceiver

This block is the serial voice port of a two-channel line card. It sits on one or more PCM highways. Each highway has a transmit line and a receive line, and all highways share one bit clock and one 8 kHz frame sync. The bit clock and the frame sync are sampled by the faster system clock, so every timing decision is made in a single clock domain.

Each channel has its own transmit slot, receive slot, transmit highway and receive highway. In its transmit slot, a channel shifts an 8-bit sample out most significant bit first, and it raises a per-channel driver-control output for the length of that slot. In its receive slot, it shifts 8 bits in from the selected highway and presents them with a one-cycle valid strobe.

The bit clock can run at the data rate or at twice the data rate. The transmit launch edge and the receive sampling edge are chosen independently. An option keeps the transmit line undriven during zero bits. The number of usable slots comes from the length of the previous frame.

Top module: `pcm_slot_xcvr`

## Requirements
- R1: While `rst_n` is low, and until the first bit-clock edge after reset, `dx_oe`, `tco` and `rx_valid` are all 0 and `rx_data` is 0.
- R2: A bit-clock rising edge at which `fsync` is high starts bit 0 of slot 0. Slot n covers frame bits 8n to 8n+7. A bit lasts one bit-clock period when `dbl_clk`=0 and two periods when `dbl_clk`=1.
- R3: The slot count of a frame is floor(bits of the previous frame / 8). It is 0 during the first frame after reset. A channel whose slot number is not below the count neither transmits nor receives in that frame.
- R4: In its transmit slot, a channel takes `tx_data` at the launch of the slot's first bit. It drives that value on highway `tx_hw` as bit 7 first, down to bit 0.
- R5: With `tx_rise`=1 each bit is launched on the rising edge that starts it. With `tx_rise`=0 it is launched on the first falling edge after that rising edge.
- R6: `tco[c]` is high from the launch of the first bit of channel c's transmit slot until the next launch that falls outside the slot. `dx_oe` of a highway is 0 unless some channel is in its slot on that highway.
- R7: With `no_zero`=1 a highway's `dx_oe` is 1 only while the bit being sent is 1.
- R8: Receive sampling edge, numbered within the bit. With `dbl_clk`=0: the rising edge that starts the bit if `rx_rise`=1, otherwise the falling edge that follows it. With `dbl_clk`=1: the second rising edge if `rx_rise`=1, otherwise the second falling edge.
- R9: A channel shifts in the 8 bits of its receive slot from highway `rx_hw`, MSB first. After the eighth bit is sampled, `rx_data` takes the byte and `rx_valid` is high for exactly one clock.
- R10: When two channels are in their transmit slots on the same highway, the lower-numbered channel owns that highway's `dx` and `dx_oe`.
- R11: Outputs change only at the second system-clock edge after a bit-clock transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk | input | 1 | Highway bit clock |
| fsync | input | 1 | Frame sync, sampled on bit-clock rising edges |
| dr | input | NHW | Receive data line per highway |
| dx | output | NHW | Transmit data per highway |
| dx_oe | output | NHW | Transmit output enable per highway (low = high-impedance) |
| dbl_clk | input | 1 | 1: bit clock at twice the data rate |
| tx_rise | input | 1 | Transmit launch edge select |
| rx_rise | input | 1 | Receive sampling edge select |
| no_zero | input | 1 | Do not drive zero bits |
| tx_slot | input | NCH*SLOT_W | Transmit slot per channel |
| rx_slot | input | NCH*SLOT_W | Receive slot per channel |
| tx_hw | input | NCH*HW_W | Transmit highway per channel |
| rx_hw | input | NCH*HW_W | Receive highway per channel |
| tx_data | input | NCH*8 | Sample to send per channel |
| rx_data | output | NCH*8 | Last received sample per channel |
| rx_valid | output | NCH | One-cycle strobe when `rx_data` is updated |
| tco | output | NCH | Per-channel external driver enable |

## Verification
The assertions take for granted the following input conditions:
- Every level of the bit clock lasts at least two system clocks.
- The configuration inputs stay constant between resets.
- The bit clock is held low during reset and for the first cycles after it. This keeps the edge-timing properties from seeing a transition that reset masked.

The stimulus meets these conditions as follows:
- The bench changes `pclk`, `fsync`, `dr` and `tx_data` together on a falling system-clock edge, with each bit-clock level lasting four system clocks.
- It changes the configuration only while reset is asserted.
- It starts every run with the bit clock low.

// File: rtl/pcm_slot_xcvr.sv
module pcm_slot_xcvr #(
  parameter int NCH       = 2,
  parameter int NHW       = 2,
  parameter int MAX_SLOTS = 128,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int HW_W     = (NHW > 1) ? $clog2(NHW) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pclk,
  input  logic                        fsync,
  input  logic [NHW-1:0]              dr,
  output logic [NHW-1:0]              dx,
  output logic [NHW-1:0]              dx_oe,
  input  logic                        dbl_clk,
  input  logic                        tx_rise,
  input  logic                        rx_rise,
  input  logic                        no_zero,
  input  logic [NCH-1:0][SLOT_W-1:0]  tx_slot,
  input  logic [NCH-1:0][SLOT_W-1:0]  rx_slot,
  input  logic [NCH-1:0][HW_W-1:0]    tx_hw,
  input  logic [NCH-1:0][HW_W-1:0]    rx_hw,
  input  logic [NCH-1:0][7:0]         tx_data,
  output logic [NCH-1:0][7:0]         rx_data,
  output logic [NCH-1:0]              rx_valid,
  output logic [NCH-1:0]              tco
);
  localparam int BIT_W = SLOT_W + 3;
  localparam logic [BIT_W-1:0] BCNT_MAX = '1;

  logic           pclk_q, pclk_d, fs_q;
  logic [NHW-1:0] dr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pclk_q <= 1'b0;
      pclk_d <= 1'b0;
      fs_q   <= 1'b0;
      dr_q   <= '0;
    end else begin
      pclk_q <= pclk;
      pclk_d <= pclk_q;
      fs_q   <= fsync;
      dr_q   <= dr;
    end

  wire rise = pclk_q & ~pclk_d;
  wire fall = ~pclk_q & pclk_d;
  wire ev   = rise | fall;
  wire frame_start = rise & fs_q;
  wire [1:0] ph_last = dbl_clk ? 2'd3 : 2'd1;

  logic [1:0]       ph, ph_n;
  logic [BIT_W-1:0] bcnt, bcnt_n;
  logic [SLOT_W:0]  nslots, nslots_n, fslots;
  logic             synced;

  assign fslots = (SLOT_W+1)'(({1'b0, bcnt} + 1'b1) >> 3);

  always_comb begin
    ph_n     = ph;
    bcnt_n   = bcnt;
    nslots_n = nslots;
    if (frame_start) begin
      ph_n   = 2'd0;
      bcnt_n = '0;
      if (synced) nslots_n = fslots;
    end else if (ev) begin
      if (ph == ph_last) begin
        ph_n = 2'd0;
        if (bcnt != BCNT_MAX) bcnt_n = bcnt + 1'b1;
      end else begin
        ph_n = ph + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph     <= 2'd0;
      bcnt   <= '0;
      nslots <= '0;
      synced <= 1'b0;
    end else begin
      ph     <= ph_n;
      bcnt   <= bcnt_n;
      nslots <= nslots_n;
      if (frame_start) synced <= 1'b1;
    end

  wire [SLOT_W-1:0] cur_slot = bcnt_n[BIT_W-1:3];
  wire [2:0]        cur_pos  = bcnt_n[2:0];
  wire tx_ev = ev && (ph_n == (tx_rise ? 2'd0 : 2'd1));
  wire rx_ev = ev && (ph_n == {dbl_clk, ~rx_rise});

  logic [NCH-1:0] drv_v, bit_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] tx_sh;
    logic [6:0] rx_sh;
    logic       drv, bitv, rv;
    logic [7:0] rd;
    wire tx_hit = ({1'b0, tx_slot[c]} < nslots_n) && (cur_slot == tx_slot[c]);
    wire rx_hit = ({1'b0, rx_slot[c]} < nslots_n) && (cur_slot == rx_slot[c]);
    wire din    = dr_q[rx_hw[c]];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        drv   <= 1'b0;
        bitv  <= 1'b0;
        tx_sh <= '0;
      end else if (tx_ev) begin
        drv <= tx_hit;
        if (tx_hit) begin
          if (cur_pos == 3'd0) begin
            tx_sh <= tx_data[c];
            bitv  <= tx_data[c][7];
          end else begin
            bitv  <= tx_sh[3'd7 - cur_pos];
          end
        end
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rx_sh <= '0;
        rd    <= '0;
        rv    <= 1'b0;
      end else begin
        rv <= 1'b0;
        if (rx_ev && rx_hit) begin
          rx_sh <= {rx_sh[5:0], din};
          if (cur_pos == 3'd7) begin
            rd <= {rx_sh, din};
            rv <= 1'b1;
          end
        end
      end

    assign drv_v[c]    = drv;
    assign bit_v[c]    = bitv;
    assign rx_data[c]  = rd;
    assign rx_valid[c] = rv;
  end

  assign tco = drv_v;

  always_comb begin
    dx    = '0;
    dx_oe = '0;
    for (int h = 0; h < NHW; h++)
      for (int c = NCH-1; c >= 0; c--)
        if (drv_v[c] && tx_hw[c] == HW_W'(h)) begin
          dx[h]    = bit_v[c];
          dx_oe[h] = bit_v[c] | ~no_zero;
        end
  end
endmodule

// File: rtl/pcm_slot_xcvr_chk.sv
module pcm_slot_xcvr_chk #(
  parameter int NCH = 2,
  parameter int NHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pclk,
  input logic           no_zero,
  input logic [NHW-1:0] dx,
  input logic [NHW-1:0] dx_oe,
  input logic [NCH-1:0] tco,
  input logic [NCH-1:0] rx_valid
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[c] |=> !rx_valid[c]);
    a_r11_valid_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[c] |-> ($past(pclk, 2) != $past(pclk, 3)));
    a_r11_tco_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tco[c]) |-> ($past(pclk, 2) != $past(pclk, 3)));
  end

  for (genvar h = 0; h < NHW; h++) begin : g_hw
    a_r7_no_zero_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (no_zero && dx_oe[h]) |-> dx[h]);
    a_r6_oe_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
      dx_oe[h] |-> (|tco));
  end
endmodule

bind pcm_slot_xcvr pcm_slot_xcvr_chk #(.NCH(NCH), .NHW(NHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pclk(pclk), .no_zero(no_zero),
  .dx(dx), .dx_oe(dx_oe), .tco(tco), .rx_valid(rx_valid)
);

// File: tb/sim_pcm_slot_xcvr.sv
module sim_pcm_slot_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, NHW = 2, MS = 128, SW = 7, HWW = 1;

  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b0, fsync = 1'b0;
  logic [NHW-1:0] dr = '0;
  logic [NHW-1:0] dx, dx_oe;
  logic dbl_clk = 0, tx_rise = 1, rx_rise = 0, no_zero = 0;
  logic [NCH-1:0][SW-1:0]  tx_slot = '0, rx_slot = '0;
  logic [NCH-1:0][HWW-1:0] tx_hw = '0, rx_hw = '0;
  logic [NCH-1:0][7:0] tx_data = '0;
  logic [NCH-1:0][7:0] rx_data;
  logic [NCH-1:0] rx_valid, tco;

  pcm_slot_xcvr #(.NCH(NCH), .NHW(NHW), .MAX_SLOTS(MS)) u0 (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .fsync(fsync), .dr(dr),
    .dx(dx), .dx_oe(dx_oe), .dbl_clk(dbl_clk), .tx_rise(tx_rise),
    .rx_rise(rx_rise), .no_zero(no_zero), .tx_slot(tx_slot),
    .rx_slot(rx_slot), .tx_hw(tx_hw), .rx_hw(rx_hw), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .tco(tco));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, prev_len = 0, m_nslots = 0;
  bit done = 0;
  bit m_drv[NCH], m_bit[NCH], m_val[NCH];
  logic [7:0] m_samp[NCH], m_rsh[NCH], m_rdat[NCH];

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_drv[c] = 0; m_bit[c] = 0; m_val[c] = 0;
      m_samp[c] = 0; m_rsh[c] = 0; m_rdat[c] = 0;
    end
    prev_len = 0; m_nslots = 0;
  endtask

  task automatic model_step(int b, int h);
    int slot = b / 8, pos = b % 8;
    int sh = (dbl_clk ? 2 : 0) + (rx_rise ? 0 : 1);
    for (int c = 0; c < NCH; c++) m_val[c] = 0;
    if (h == (tx_rise ? 0 : 1))
      for (int c = 0; c < NCH; c++) begin
        bit hit = (int'(tx_slot[c]) < m_nslots) && (slot == int'(tx_slot[c]));
        m_drv[c] = hit;
        if (hit) begin
          if (pos == 0) m_samp[c] = tx_data[c];
          m_bit[c] = m_samp[c][7-pos];
        end
      end
    if (h == sh)
      for (int c = 0; c < NCH; c++)
        if ((int'(rx_slot[c]) < m_nslots) && (slot == int'(rx_slot[c]))) begin
          m_rsh[c] = {m_rsh[c][6:0], dr[rx_hw[c]]};
          if (pos == 7) begin m_rdat[c] = m_rsh[c]; m_val[c] = 1; end
        end
  endtask

  task automatic compare(bit pulse_phase);
    for (int h = 0; h < NHW; h++) begin
      bit e_oe = 0, e_dx = 0;
      for (int c = NCH-1; c >= 0; c--)
        if (m_drv[c] && int'(tx_hw[c]) == h) begin
          e_dx = m_bit[c];
          e_oe = m_bit[c] | !no_zero;
        end
      chk("R6", "dx_oe", int'(dx_oe[h]), int'(e_oe));
      if (e_oe) chk("R4", "dx", int'(dx[h]), int'(e_dx));
    end
    for (int c = 0; c < NCH; c++) begin
      chk("R6", "tco", int'(tco[c]), int'(m_drv[c]));
      chk("R9", "rx_valid", int'(rx_valid[c]), int'(pulse_phase && m_val[c]));
      chk("R9", "rx_data", int'(rx_data[c]), int'(m_rdat[c]));
    end
  endtask

  task automatic run_frame(int nb);
    int hb = dbl_clk ? 4 : 2;
    for (int b = 0; b < nb; b++)
      for (int h = 0; h < hb; h++) begin
        @(negedge clk);
        pclk = (h % 2 == 0);
        if (h == 0) begin
          fsync = (b == 0);
          dr = NHW'($urandom);
          if (b == 0) m_nslots = (prev_len / 8 > MS) ? MS : prev_len / 8;
        end else if (h == 1) fsync = 0;
        tx_data = (NCH*8)'($urandom);
        model_step(b, h);
        @(negedge clk);
        @(negedge clk);
        compare(1);  // R11: settled on the second clock edge after the toggle
        @(negedge clk);
        compare(0);
      end
    prev_len = nb;
  endtask

  task automatic start(bit dbl, bit txr, bit rxr, bit nz);
    rst_n = 0; pclk = 0; fsync = 0; dr = '0;
    dbl_clk = dbl; tx_rise = txr; rx_rise = rxr; no_zero = nz;
    model_clear();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "dx_oe", int'(dx_oe), 0);
    chk("R1", "tco", int'(tco), 0);
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "rx_data", int'(rx_data), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "tco after release", int'(tco), 0);
  endtask

  initial begin
    // R2 R5 R8: single clock, rising launch, falling sample
    tx_slot[0] = 1; tx_hw[0] = 0; rx_slot[0] = 2; rx_hw[0] = 1;
    tx_slot[1] = 3; tx_hw[1] = 1; rx_slot[1] = 0; rx_hw[1] = 0;
    start(0, 1, 0, 0);
    repeat (3) run_frame(32);

    // R2 R5 R7 R8: double clock, falling launch, second rising sample, zero bits undriven
    tx_slot[0] = 0; tx_hw[0] = 1; rx_slot[0] = 3; rx_hw[0] = 0;
    tx_slot[1] = 2; tx_hw[1] = 0; rx_slot[1] = 1; rx_hw[1] = 1;
    start(1, 0, 1, 1);
    repeat (3) run_frame(32);

    // R3: slot count follows previous frame length; slots beyond it are silent
    tx_slot[0] = 2; tx_hw[0] = 0; rx_slot[0] = 4; rx_hw[0] = 1;
    tx_slot[1] = 4; tx_hw[1] = 1; rx_slot[1] = 1; rx_hw[1] = 0;
    start(0, 0, 1, 0);
    run_frame(40); run_frame(20); run_frame(40); run_frame(40);

    // R10: both channels in slot 1 on highway 0, channel 0 wins
    tx_slot[0] = 1; tx_hw[0] = 0; rx_slot[0] = 1; rx_hw[0] = 0;
    tx_slot[1] = 1; tx_hw[1] = 0; rx_slot[1] = 1; rx_hw[1] = 1;
    start(1, 1, 0, 0);
    repeat (3) run_frame(24);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule